// File: doc/BRIEF.md
# Passive LCD Scan Timing Generator

This block produces the scan strobes for a passive-matrix STN panel: a shift clock for pixel transfers, a line pulse at the end of every row, a frame pulse that marks the first row of each frame, and an AC-drive signal that reverses panel polarity at a chosen rate. The shift clock is divided down from the reference clock by a programmable even ratio. Each row is made up of a number of transfer slots followed by one line-pulse slot.

A pixel fetcher outside the block watches `data_req`. It presents one transfer's worth of pixels on `pix_data` for the whole slot that the request opens. The block masks that value to the bus mode, applies the inversion control and blanks it when the display is off, then places it on `lcd_data`. The split-panel and 8-bit bus modes both use the full 8 data lines: on a split panel each half gets one nibble. A 4-bit single panel uses only the low nibble.

The timing and mode inputs are copied into shadow registers. This happens while video is disabled and again at each frame boundary, so a change made mid-frame never tears a frame.

Top module: `lcd_scan_timer`

## Requirements
- R1: With divider value D, the shift-clock slot lasts 2*(D+1) reference cycles. `shift_clk` is low for the first D+1 cycles of each transfer slot and high for the remaining D+1.
- R2: A row has X+1 transfer slots, where X is `cfg_xfers`, followed by one line-pulse slot of the same length. `line_pulse` is high for exactly that slot, and `shift_clk` stays low throughout it.
- R3: `data_req` is high for one reference cycle: the first cycle of every transfer slot. It is never high in a line-pulse slot.
- R4: `line_count` runs 0,1,...,L and wraps to 0, where L is `cfg_lines`. It advances at the end of each line-pulse slot. `frame_pulse` is high for the whole of row 0, including that row's line-pulse slot.
- R5: With `cfg_ac_by_lines`=1, `ac_drive` starts low and toggles after every A+1 completed rows, where A is `cfg_acdiv`. The row counting runs on across frame boundaries.
- R6: With `cfg_ac_by_lines`=0, `ac_drive` starts low and toggles at the end of every frame.
- R7: During a transfer slot, `lcd_data` equals `pix_data`, bitwise inverted when `cfg_invert`=1. When neither `cfg_split` nor `cfg_bus8` is set, bits 7:4 are forced to 0. `lcd_data` is 0 during a line-pulse slot.
- R8: With `cfg_display`=0, `disp_on` is low and `lcd_data` is 0, while all scan timing keeps running. With `cfg_display`=1, `disp_on` is high while video runs.
- R9: One cycle after `cfg_enable` is sampled low, every output is 0. After `cfg_enable` rises, the first active cycle is cycle 0 of row 0, transfer slot 0, and `ac_drive` is low.
- R10: Configuration inputs are captured while disabled and at each frame boundary. A change made mid-frame leaves the current frame unchanged, and the new values apply from the first cycle of the next frame.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Video enable; low holds all counters at zero |
| cfg_display | input | 1 | Display on; low blanks the pixel data |
| cfg_invert | input | 1 | Invert pixel data |
| cfg_split | input | 1 | Split (dual) panel, one nibble per half |
| cfg_bus8 | input | 1 | 8-bit data bus on a single panel |
| cfg_ac_by_lines | input | 1 | 1: AC toggle by row count; 0: AC toggle per frame |
| cfg_clkdiv | input | 5 | Shift-clock divider value D |
| cfg_xfers | input | 9 | Transfers per row minus one |
| cfg_lines | input | 10 | Rows per frame (per half when split) minus one |
| cfg_acdiv | input | 8 | Rows per AC toggle minus one |
| pix_data | input | 8 | Pixels for the current transfer |
| shift_clk | output | 1 | Pixel shift clock |
| line_pulse | output | 1 | Row latch pulse |
| frame_pulse | output | 1 | First-row marker |
| ac_drive | output | 1 | Polarity reversal signal |
| disp_on | output | 1 | Display enable to the panel |
| data_req | output | 1 | One-cycle request for the next transfer's pixels |
| lcd_data | output | 8 | Panel data lines |
| line_count | output | 10 | Current row, readable status |

## Verification
The assertions assume that `pix_data` is meaningful only inside transfer slots. They also assume that the configuration fields are free to change at any time, because the shadow copy is what the logic uses. The stimulus changes configuration only while `cfg_enable` is low, with one exception. That is a deliberate mid-frame change made while running, and only the timing fields change in it. This keeps the expected behaviour a simple function of the reference-cycle count since enable. The bench sweeps small divider, transfer and row values across all four bus modes, and drives a different pixel value on each cycle.

// File: rtl/lst_pkg.sv
package lst_pkg;
  localparam int DIV_W  = 5;
  localparam int XFER_W = 9;
  localparam int LINE_W = 10;
  localparam int AC_W   = 8;
  localparam int NIB_W  = 4;

  typedef struct packed {
    logic split;
    logic bus8;
    logic ac_by_lines;
    logic invert;
    logic disp_on;
  } scan_mode_t;

  // True when both nibbles of the data bus carry pixels.
  function automatic logic wide_bus(input scan_mode_t m);
    return m.split | m.bus8;
  endfunction
endpackage

// File: rtl/lst_sclk_div.sv
module lst_sclk_div #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_last,
  output logic             lvl,
  output logic             slot_end,
  output logic             slot_start
);
  logic [DIV_W-1:0] cnt;
  logic             half_done;

  assign half_done = (cnt == half_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (half_done) begin
      cnt <= '0;
      lvl <= ~lvl;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Last cycle of the high half closes a slot; first cycle of the low half opens one.
  assign slot_end   = run & half_done & lvl;
  assign slot_start = run & (cnt == '0) & ~lvl;
endmodule

// File: rtl/lst_scan_ctr.sv
module lst_scan_ctr #(
  parameter int XFER_W = 9,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              slot_end,
  input  logic [XFER_W-1:0] xfer_last,
  input  logic [LINE_W-1:0] line_last,
  output logic [LINE_W-1:0] line,
  output logic              lp_slot,
  output logic              line_end,
  output logic              frame_end
);
  localparam int COL_W = XFER_W + 1;

  logic [COL_W-1:0] col;
  logic [COL_W-1:0] col_last;
  logic             line_wrap;

  // One extra slot after the final transfer carries the line pulse.
  assign col_last  = COL_W'(xfer_last) + COL_W'(1);
  assign lp_slot   = (col == col_last);
  assign line_wrap = (line == line_last);
  assign line_end  = slot_end & lp_slot;
  assign frame_end = line_end & line_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col  <= '0;
      line <= '0;
    end else if (!run) begin
      col  <= '0;
      line <= '0;
    end else if (slot_end) begin
      if (lp_slot) begin
        col  <= '0;
        line <= line_wrap ? '0 : line + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lst_ac_drive.sv
module lst_ac_drive #(
  parameter int AC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            by_lines,
  input  logic [AC_W-1:0] ac_last,
  input  logic            line_end,
  input  logic            frame_end,
  output logic            ac
);
  logic [AC_W-1:0] cnt;
  logic            flip;

  assign flip = by_lines ? (line_end & (cnt == ac_last)) : frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ac  <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      ac  <= 1'b0;
    end else begin
      if (by_lines && line_end) begin
        cnt <= (cnt == ac_last) ? '0 : cnt + 1'b1;
      end
      if (flip) begin
        ac <= ~ac;
      end
    end
  end
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int DIV_W  = lst_pkg::DIV_W,
  parameter int XFER_W = lst_pkg::XFER_W,
  parameter int LINE_W = lst_pkg::LINE_W,
  parameter int AC_W   = lst_pkg::AC_W,
  parameter int NIB_W  = lst_pkg::NIB_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_enable,
  input  logic                 cfg_display,
  input  logic                 cfg_invert,
  input  logic                 cfg_split,
  input  logic                 cfg_bus8,
  input  logic                 cfg_ac_by_lines,
  input  logic [DIV_W-1:0]     cfg_clkdiv,
  input  logic [XFER_W-1:0]    cfg_xfers,
  input  logic [LINE_W-1:0]    cfg_lines,
  input  logic [AC_W-1:0]      cfg_acdiv,
  input  logic [2*NIB_W-1:0]   pix_data,
  output logic                 shift_clk,
  output logic                 line_pulse,
  output logic                 frame_pulse,
  output logic                 ac_drive,
  output logic                 disp_on,
  output logic                 data_req,
  output logic [2*NIB_W-1:0]   lcd_data,
  output logic [LINE_W-1:0]    line_count
);
  import lst_pkg::*;

  localparam int DATA_W = 2 * NIB_W;

  // Shadow copy of the configuration
  logic              run;
  logic [DIV_W-1:0]  sh_div;
  logic [XFER_W-1:0] sh_xfer;
  logic [LINE_W-1:0] sh_line;
  logic [AC_W-1:0]   sh_ac;
  scan_mode_t        sh_mode;
  scan_mode_t        in_mode;

  // Named internal events
  logic              sclk_lvl;
  logic              slot_end;
  logic              slot_start;
  logic [LINE_W-1:0] line;
  logic              lp_slot;
  logic              line_end;
  logic              frame_end;
  logic              ac_q;
  logic              sh_load;

  function automatic logic [DATA_W-1:0] shape_pixels(input logic [DATA_W-1:0] px,
                                                      input scan_mode_t m);
    logic [DATA_W-1:0] v;
    v = m.invert ? ~px : px;
    if (!wide_bus(m)) v[DATA_W-1:NIB_W] = '0;
    return v;
  endfunction

  assign in_mode = '{split: cfg_split, bus8: cfg_bus8, ac_by_lines: cfg_ac_by_lines,
                     invert: cfg_invert, disp_on: cfg_display};
  assign sh_load = ~run | frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
    end else begin
      run <= cfg_enable;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_div  <= '0;
      sh_xfer <= '0;
      sh_line <= '0;
      sh_ac   <= '0;
      sh_mode <= '0;
    end else if (sh_load) begin
      sh_div  <= cfg_clkdiv;
      sh_xfer <= cfg_xfers;
      sh_line <= cfg_lines;
      sh_ac   <= cfg_acdiv;
      sh_mode <= in_mode;
    end
  end

  lst_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .half_last (sh_div),
    .lvl       (sclk_lvl),
    .slot_end  (slot_end),
    .slot_start(slot_start)
  );

  lst_scan_ctr #(.XFER_W(XFER_W), .LINE_W(LINE_W)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .slot_end (slot_end),
    .xfer_last(sh_xfer),
    .line_last(sh_line),
    .line     (line),
    .lp_slot  (lp_slot),
    .line_end (line_end),
    .frame_end(frame_end)
  );

  lst_ac_drive #(.AC_W(AC_W)) u_ac (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .by_lines (sh_mode.ac_by_lines),
    .ac_last  (sh_ac),
    .line_end (line_end),
    .frame_end(frame_end),
    .ac       (ac_q)
  );

  assign shift_clk   = run & sclk_lvl & ~lp_slot;
  assign line_pulse  = run & lp_slot;
  assign frame_pulse = run & (line == '0);
  assign ac_drive    = run & ac_q;
  assign disp_on     = run & sh_mode.disp_on;
  assign data_req    = slot_start & ~lp_slot;
  assign line_count  = run ? line : '0;
  assign lcd_data    = (run && sh_mode.disp_on && !lp_slot) ? shape_pixels(pix_data, sh_mode)
                                                             : '0;
endmodule

// File: rtl/lcd_scan_timer_chk.sv
module lcd_scan_timer_chk #(
  parameter int LINE_W = 10,
  parameter int NIB_W  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_enable,
  input logic                shift_clk,
  input logic                line_pulse,
  input logic                frame_pulse,
  input logic                ac_drive,
  input logic                disp_on,
  input logic                data_req,
  input logic [2*NIB_W-1:0]  lcd_data,
  input logic [LINE_W-1:0]   line_count
);
  p_lp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |-> (!shift_clk && !data_req));

  p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |=> !data_req);

  p_frame_row0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (line_count == '0));

  p_row_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_count) |-> (line_count == '0 || line_count == LINE_W'($past(line_count) + 1'b1)));

  p_ac_on_row_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ac_drive) |-> ($past(line_pulse) || !$past(cfg_enable)));

  p_no_data_in_lp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |-> (lcd_data == '0));

  p_blank_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (lcd_data == '0));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!shift_clk && !line_pulse && !frame_pulse && !ac_drive &&
                     !disp_on && !data_req && lcd_data == '0 && line_count == '0));
endmodule

bind lcd_scan_timer lcd_scan_timer_chk #(.LINE_W(LINE_W), .NIB_W(NIB_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_enable (cfg_enable),
  .shift_clk  (shift_clk),
  .line_pulse (line_pulse),
  .frame_pulse(frame_pulse),
  .ac_drive   (ac_drive),
  .disp_on    (disp_on),
  .data_req   (data_req),
  .lcd_data   (lcd_data),
  .line_count (line_count)
);

// File: tb/lcd_scan_timer_tb.sv
module lcd_scan_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_enable, cfg_display, cfg_invert, cfg_split, cfg_bus8, cfg_ac_by_lines;
  logic [4:0] cfg_clkdiv;
  logic [8:0] cfg_xfers;
  logic [9:0] cfg_lines;
  logic [7:0] cfg_acdiv;
  logic [7:0] pix_data;
  logic       shift_clk, line_pulse, frame_pulse, ac_drive, disp_on, data_req;
  logic [7:0] lcd_data;
  logic [9:0] line_count;

  int n_tests = 0;
  int n_fail  = 0;

  // Old and new timing sets; fsw is the cycle where the new set applies.
  int oD, oX, oL, oA, nD, nX, nL, nA, fsw;
  bit o_acm, n_acm;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_scan_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_display(cfg_display),
    .cfg_invert(cfg_invert), .cfg_split(cfg_split), .cfg_bus8(cfg_bus8),
    .cfg_ac_by_lines(cfg_ac_by_lines), .cfg_clkdiv(cfg_clkdiv), .cfg_xfers(cfg_xfers),
    .cfg_lines(cfg_lines), .cfg_acdiv(cfg_acdiv), .pix_data(pix_data),
    .shift_clk(shift_clk), .line_pulse(line_pulse), .frame_pulse(frame_pulse),
    .ac_drive(ac_drive), .disp_on(disp_on), .data_req(data_req),
    .lcd_data(lcd_data), .line_count(line_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input int d, input int x, input int l, input int a, input bit acm);
    cfg_clkdiv = 5'(d); cfg_xfers = 9'(x); cfg_lines = 10'(l); cfg_acdiv = 8'(a);
    cfg_ac_by_lines = acm;
  endtask

  task automatic check_idle(input string req);
    @(negedge clk); #1;
    chk(req, "shift_clk", int'(shift_clk), 0);
    chk(req, "line_pulse", int'(line_pulse), 0);
    chk(req, "frame_pulse", int'(frame_pulse), 0);
    chk(req, "ac_drive", int'(ac_drive), 0);
    chk(req, "disp_on", int'(disp_on), 0);
    chk(req, "data_req", int'(data_req), 0);
    chk(req, "lcd_data", int'(lcd_data), 0);
    chk(req, "line_count", int'(line_count), 0);
  endtask

  // Compare every output at cycle k since enable against the arithmetic model.
  task automatic check_k(input int k, input bit chk_ac, input string tag);
    int d, x, l, a, kk, per, n, ph, col, nl, ln, e_data;
    bit acm, lp;
    if (k < fsw) begin d = oD; x = oX; l = oL; a = oA; acm = o_acm; kk = k; end
    else begin d = nD; x = nX; l = nL; a = nA; acm = n_acm; kk = k - fsw; end
    per = 2 * (d + 1);
    n   = kk / per;
    ph  = kk % per;
    col = n % (x + 2);
    nl  = n / (x + 2);
    ln  = nl % (l + 1);
    lp  = (col == x + 1);
    if (lp || !cfg_display) e_data = 0;
    else begin
      e_data = cfg_invert ? (~int'(pix_data) & 255) : int'(pix_data);
      if (!cfg_split && !cfg_bus8) e_data = e_data & 15;
    end
    chk((tag == "") ? "R1" : tag, "shift_clk", int'(shift_clk), int'((ph >= d + 1) && !lp));
    chk((tag == "") ? "R2" : tag, "line_pulse", int'(line_pulse), int'(lp));
    chk((tag == "") ? "R3" : tag, "data_req", int'(data_req), int'(ph == 0 && !lp));
    chk((tag == "") ? "R4" : tag, "frame_pulse", int'(frame_pulse), int'(ln == 0));
    chk((tag == "") ? "R4" : tag, "line_count", int'(line_count), ln);
    if (chk_ac) begin
      if (acm) chk("R5", "ac_drive", int'(ac_drive), (nl / (a + 1)) % 2);
      else     chk("R6", "ac_drive", int'(ac_drive), (nl / (l + 1)) % 2);
    end
    chk("R7", "lcd_data", int'(lcd_data), e_data);
    chk("R8", "disp_on", int'(disp_on), int'(cfg_display));
  endtask

  task automatic run_span(input int k0, input int cnt, input bit chk_ac, input string tag);
    for (int k = k0; k < k0 + cnt; k++) begin
      @(negedge clk);
      pix_data = 8'((k * 53 + 17) ^ (k >> 3));
      #1;
      check_k(k, chk_ac, tag);
    end
  endtask

  task automatic start_run(input int d, input int x, input int l, input int a, input bit acm);
    set_cfg(d, x, l, a, acm);
    oD = d; oX = x; oL = l; oA = a; o_acm = acm;
    nD = d; nX = x; nL = l; nA = a; n_acm = acm;
    fsw = 1 << 30;
    @(negedge clk);
    cfg_enable = 1'b1;
  endtask

  task automatic stop_run();
    @(negedge clk);
    cfg_enable = 1'b0;
  endtask

  function automatic int frame_len(input int d, input int x, input int l);
    return 2 * (d + 1) * (x + 2) * (l + 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_enable = 1'b0; cfg_display = 1'b1; cfg_invert = 1'b0;
    cfg_split = 1'b0; cfg_bus8 = 1'b0; pix_data = 8'h00;
    set_cfg(0, 0, 0, 0, 1'b0);

    // R11: reset state, with enable already high to prove reset dominates
    cfg_enable = 1'b1;
    check_idle("R11");
    check_idle("R11");
    cfg_enable = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check_idle("R9");

    // R1..R7 sweep over divider, transfers, rows and all bus modes
    for (int d = 0; d < 3; d++) begin
      for (int xi = 0; xi < 2; xi++) begin
        for (int li = 0; li < 3; li++) begin
          for (int m = 0; m < 4; m++) begin
            int x, l, a;
            x = (xi == 0) ? 0 : 2;
            l = (li == 0) ? 0 : ((li == 1) ? 1 : 3);
            a = (d + li + m) % 3;
            cfg_split  = m[0];
            cfg_bus8   = m[1];
            cfg_invert = ((d + li) % 2) == 1;
            cfg_display = 1'b1;
            start_run(d, x, l, a, ((xi + m) % 2) == 1);
            run_span(0, 2 * frame_len(d, x, l) + 3, 1'b1, "");
            stop_run();
            check_idle("R9");
            check_idle("R9");
          end
        end
      end
    end

    // R8: display off blanks data, timing continues
    cfg_display = 1'b0; cfg_invert = 1'b1; cfg_bus8 = 1'b1; cfg_split = 1'b0;
    start_run(1, 2, 2, 1, 1'b1);
    run_span(0, frame_len(1, 2, 2) + 5, 1'b1, "R8");
    stop_run();
    check_idle("R9");
    cfg_display = 1'b1;

    // R9: stop mid-frame, then restart from row 0 slot 0
    cfg_invert = 1'b0; cfg_split = 1'b1; cfg_bus8 = 1'b0;
    start_run(1, 2, 3, 0, 1'b1);
    run_span(0, 37, 1'b1, "R9");
    stop_run();
    check_idle("R9");
    check_idle("R9");
    check_idle("R9");
    start_run(1, 2, 3, 0, 1'b1);
    run_span(0, frame_len(1, 2, 3) + 4, 1'b1, "R9");
    stop_run();
    check_idle("R9");

    // R10: mid-frame change waits for the frame boundary
    cfg_split = 1'b0; cfg_bus8 = 1'b0;
    start_run(1, 1, 2, 0, 1'b0);
    run_span(0, frame_len(1, 1, 2) / 2, 1'b0, "R10");
    set_cfg(0, 3, 1, 0, 1'b0);
    nD = 0; nX = 3; nL = 1; nA = 0; n_acm = 1'b0;
    fsw = frame_len(1, 1, 2);
    run_span(frame_len(1, 1, 2) / 2, fsw - frame_len(1, 1, 2) / 2 + 2 * frame_len(0, 3, 1),
             1'b0, "R10");
    stop_run();
    check_idle("R9");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule